// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the instruction fetch address for a small 8-bit controller core. It keeps a 13-bit program counter and a small hardware stack of return addresses. On every clock it acts on one sequencing command from the decoder: hold, step forward, branch to a target, branch with a saved return address, come back to a saved address, or enter the interrupt handler.

The program store behind it holds only 4096 words. The counter itself keeps all 13 bits, and only the address presented to the store is folded into the implemented range. Reset and interrupt entry load fixed vectors. A call and an interrupt entry save their return addresses on the same stack. The stack is a ring with no overflow or underflow flag.

The decoder drives one-hot command strobes and a 13-bit target. The core reads back the counter, the folded fetch address and the stack occupancy. The occupancy output exists only so a testbench can observe the stack.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is low, and after it is released with no command asserted, the counter is 0x0000 and the stack depth is 0. Reset asserts asynchronously and is released on the second rising clock edge after `rst_n` rises.
- R2: With only `cmd_inc` asserted, the counter becomes its previous value plus one modulo 8192 on the next clock, so 0x1FFF steps to 0x0000.
- R3: With no command asserted, the counter and the stack depth keep their values.
- R4: With `cmd_jump` as the winning command, the counter loads all 13 bits of `target` unchanged.
- R5: With `cmd_call` as the winning command, the counter plus one modulo 8192 is pushed on the stack and the counter loads `target`.
- R6: With `cmd_ret` as the winning command, the most recently pushed entry is popped into the counter.
- R7: With `cmd_irq` asserted, the counter plus one modulo 8192 is pushed on the stack and the counter loads 0x0004.
- R8: When several commands are asserted together, only one acts, chosen in the order irq, ret, call, jump, inc.
- R9: `fetch_addr` always equals the low 12 bits of the counter, so counter values of 0x1000 and above wrap into 0x000 to 0xFFF.
- R10: The stack has 8 entries arranged as a ring. A ninth push overwrites the oldest entry. A pop from an empty stack returns whatever stale entry the ring position holds. The depth output saturates at 8 and at 0, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_inc | input | 1 | Step the counter by one |
| cmd_jump | input | 1 | Load `target` into the counter |
| cmd_call | input | 1 | Push the return address and load `target` |
| cmd_ret | input | 1 | Pop the top stack entry into the counter |
| cmd_irq | input | 1 | Push the return address and load the interrupt vector |
| target | input | 13 | Branch or call destination |
| pc_q | output | 13 | Current program counter |
| fetch_addr | output | 12 | Address to the program store, folded into 4K words |
| stk_depth | output | 4 | Stack occupancy, 0 to 8, saturating |

## Verification
The bench builds the block with its default parameters: a 13-bit counter, a 4096-word store and eight stack levels. At these sizes one jump to 0x1FFF reaches both the fetch fold and the counter rollover in two cycles. Ten nested calls overrun the ring, and the returns that follow run past empty into stale entries. A behavioural model built from a plain array and integers checks every cycle of directed and random command mixes, including cycles that assert several commands at once and a reset taken mid-run.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_IRQ  = 3'd5
  } seq_op_e;
endpackage

// File: rtl/pc_seq_rst_sync.sv
module pc_seq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pc_seq_arbiter.sv
module pc_seq_arbiter
  import pc_seq_pkg::*;
(
  input  logic    cmd_inc,
  input  logic    cmd_jump,
  input  logic    cmd_call,
  input  logic    cmd_ret,
  input  logic    cmd_irq,
  output seq_op_e op
);
  always_comb begin
    if (cmd_irq)       op = OP_IRQ;
    else if (cmd_ret)  op = OP_RET;
    else if (cmd_call) op = OP_CALL;
    else if (cmd_jump) op = OP_JUMP;
    else if (cmd_inc)  op = OP_INC;
    else               op = OP_HOLD;
  end

  // R8: the chosen operation always matches the highest-ranked strobe
  always_comb begin
    if (cmd_irq) a_irq_wins_r8: assert (op == OP_IRQ);
    if (!cmd_irq && cmd_ret) a_ret_wins_r8: assert (op == OP_RET);
  end
endmodule

// File: rtl/pc_seq_stack.sv
module pc_seq_stack #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] top_data,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_idx;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ptr_en;

  assign rd_idx   = wr_ptr_q - PTR_W'(1);
  assign top_data = mem_q[rd_idx];
  assign ptr_en   = push | pop;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (push) begin
      wr_ptr_d = wr_ptr_q + PTR_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + CNT_W'(1);
    end else if (pop) begin
      wr_ptr_d = rd_idx;
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (push && wr_ptr_q == PTR_W'(g)) mem_q[g] <= push_data;
    end
  end

  assign depth = cnt_q;

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  p_push_on_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_data == $past(push_data));

  p_depth_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt_q == CNT_W'(DEPTH)) |=> cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter int              MEM_AW  = 12,
  parameter int              STK_N   = 8,
  parameter logic [PC_W-1:0] RST_VEC = 13'h0000,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_inc,
  input  logic                       cmd_jump,
  input  logic                       cmd_call,
  input  logic                       cmd_ret,
  input  logic                       cmd_irq,
  input  logic [PC_W-1:0]            target,
  output logic [PC_W-1:0]            pc_q,
  output logic [MEM_AW-1:0]          fetch_addr,
  output logic [$clog2(STK_N+1)-1:0] stk_depth
);
  localparam int DEP_W = $clog2(STK_N+1);

  logic            srst_n;
  seq_op_e         op;
  logic [PC_W-1:0] pc_d, pc_r, pc_plus1, stk_top;
  logic            pc_en, push, pop;

  pc_seq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pc_seq_arbiter u_arb (
    .cmd_inc  (cmd_inc),
    .cmd_jump (cmd_jump),
    .cmd_call (cmd_call),
    .cmd_ret  (cmd_ret),
    .cmd_irq  (cmd_irq),
    .op       (op)
  );

  assign pc_plus1 = pc_r + PC_W'(1);
  assign push     = (op == OP_CALL) || (op == OP_IRQ);
  assign pop      = (op == OP_RET);
  assign pc_en    = (op != OP_HOLD);

  pc_seq_stack #(.ADDR_W(PC_W), .DEPTH(STK_N)) u_stk (
    .clk       (clk),
    .rst_n     (srst_n),
    .push      (push),
    .pop       (pop),
    .push_data (pc_plus1),
    .top_data  (stk_top),
    .depth     (stk_depth)
  );

  always_comb begin
    unique case (op)
      OP_INC:                pc_d = pc_plus1;
      OP_JUMP, OP_CALL:      pc_d = target;
      OP_RET:                pc_d = stk_top;
      OP_IRQ:                pc_d = IRQ_VEC;
      default:               pc_d = pc_r;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    pc_r <= RST_VEC;
    else if (pc_en) pc_r <= pc_d;
  end

  assign pc_q       = pc_r;
  assign fetch_addr = pc_r[MEM_AW-1:0];

  p_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (!cmd_inc && !cmd_jump && !cmd_call && !cmd_ret && !cmd_irq)
      |=> ($stable(pc_q) && $stable(stk_depth)));

  p_jump_load_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_jump && !cmd_call && !cmd_ret && !cmd_irq) |=> pc_q == $past(target));

  p_irq_vec_r7: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_irq |=> pc_q == IRQ_VEC);

  p_inc_step_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_inc && !cmd_jump && !cmd_call && !cmd_ret && !cmd_irq)
      |=> pc_q == $past(pc_q) + PC_W'(1));

  p_call_depth_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_call && !cmd_ret && !cmd_irq && stk_depth < DEP_W'(STK_N))
      |=> stk_depth == $past(stk_depth) + DEP_W'(1));
endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_inc, cmd_jump, cmd_call, cmd_ret, cmd_irq;
  logic [12:0] target;
  logic [12:0] pc_q;
  logic [11:0] fetch_addr;
  logic [3:0]  stk_depth;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  int    m_pc, m_ptr, m_depth;
  int    m_stk [8];
  string tag;

  pc_sequencer dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_inc(cmd_inc), .cmd_jump(cmd_jump), .cmd_call(cmd_call),
    .cmd_ret(cmd_ret), .cmd_irq(cmd_irq), .target(target),
    .pc_q(pc_q), .fetch_addr(fetch_addr), .stk_depth(stk_depth)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic model_push(input int v);
    m_stk[m_ptr] = v;
    m_ptr = (m_ptr + 1) % 8;
    if (m_depth < 8) m_depth++;
  endtask

  task automatic compare();
    vectors++;
    if (pc_q !== 13'(m_pc) || fetch_addr !== 12'(m_pc % 4096) ||
        stk_depth !== 4'(m_depth)) begin
      errors++;
      $display("FAIL %s: pc=%h fetch=%h depth=%0d expected pc=%h fetch=%h depth=%0d",
               tag, pc_q, fetch_addr, stk_depth, m_pc, m_pc % 4096, m_depth);
    end
  endtask

  // one cycle: check outputs, drive command, advance the model
  task automatic step(input bit i, input bit j, input bit c, input bit r,
                      input bit q, input int t, input string req);
    @(negedge clk);
    compare();
    tag = req;
    cmd_inc = i; cmd_jump = j; cmd_call = c; cmd_ret = r; cmd_irq = q;
    target = 13'(t);
    if (q) begin
      model_push((m_pc + 1) % 8192); m_pc = 4;
    end else if (r) begin
      m_ptr = (m_ptr + 7) % 8; m_pc = m_stk[m_ptr];
      if (m_depth > 0) m_depth--;
    end else if (c) begin
      model_push((m_pc + 1) % 8192); m_pc = t % 8192;
    end else if (j) begin
      m_pc = t % 8192;
    end else if (i) begin
      m_pc = (m_pc + 1) % 8192;
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {cmd_inc, cmd_jump, cmd_call, cmd_ret, cmd_irq} = '0;
    target = '0;
    m_pc = 0; m_ptr = 0; m_depth = 0;
    for (int k = 0; k < 8; k++) m_stk[k] = 0;
    tag = "R1";
    #1;
    compare();   // R1 while reset is held
    repeat (2) @(negedge clk);
    compare();
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    rst_n = 1'b0;
    {cmd_inc, cmd_jump, cmd_call, cmd_ret, cmd_irq} = '0;
    target = '0;
    apply_reset();

    // R2 increment, R3 hold
    repeat (3) step(1, 0, 0, 0, 0, 0, "R2");
    repeat (3) step(0, 0, 0, 0, 0, 13'h1ABC, "R3");
    // R4 and R9: jump high, fetch folds; R2 rollover
    step(0, 1, 0, 0, 0, 13'h1FFF, "R4");
    step(0, 0, 0, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 0, "R2");
    step(0, 1, 0, 0, 0, 13'h1234, "R9");
    // R5 calls, R6 returns
    step(0, 0, 1, 0, 0, 13'h0100, "R5");
    step(0, 0, 1, 0, 0, 13'h0200, "R5");
    step(0, 0, 1, 0, 0, 13'h1FFF, "R5");
    step(0, 0, 1, 0, 0, 13'h0300, "R5");
    repeat (4) step(0, 0, 0, 1, 0, 0, "R6");
    // R7 interrupt entry and return
    step(0, 1, 0, 0, 0, 13'h0ABC, "R4");
    step(0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 1, 0, 0, "R6");
    // R8 priority combinations
    step(1, 1, 1, 1, 1, 13'h0777, "R8");
    step(1, 1, 1, 1, 0, 13'h0777, "R8");
    step(1, 1, 1, 0, 0, 13'h0555, "R8");
    step(1, 1, 0, 0, 0, 13'h0666, "R8");
    step(0, 0, 0, 1, 0, 0, "R8");
    // R10 overrun and underrun of the ring
    for (int k = 0; k < 10; k++) step(0, 0, 1, 0, 0, 13'h0040 + k, "R10");
    for (int k = 0; k < 11; k++) step(0, 0, 0, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");

    // random mix with a reset in the middle
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 31));
      step(r[0], r[1], r[2] & r[0], r[3] & r[1], r[4] & r[3] & r[2],
           int'($urandom_range(0, 8191)), "R8");
      if (n == 300) apply_reset();
    end
    step(0, 0, 0, 0, 0, 0, "R3");
    @(negedge clk);
    compare();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule